// File: doc/BRIEF.md
# Low-Level Wake-Up Qualifier

This block decides whether a held-low interrupt pin should bring the system out of a deep sleep state, and whether that wake should also carry an interrupt request. It runs entirely on a slow, free-running oscillator clock, the only clock alive in deep sleep. The pin passes through a short synchronizer. The resulting samples must show the low level on a parameterised number of consecutive slow-clock edges before a wake is issued. Requiring consecutive samples rejects brief noise pulses on the pin.

Once a wake is issued, the block runs a start-up delay whose length is chosen by a small select input, counted in slow-clock cycles. At the last cycle of that delay it looks at the pin once more. If the level is still low, it posts a single-cycle interrupt request. If the level has gone, the wake stands on its own and no request follows. The block then returns to idle.

Qualification runs only while sleep is active, the pin is enabled and level mode is selected. The surrounding sleep controller consumes the wake pulse. The interrupt controller consumes the request pulse.

Top module: `lvl_wake_qual`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `wake_pulse` and `irq_pulse` are 0, even with the pin held low during reset.
- R2: A low level first presented to `pin_in` before rising edge e is first sampled at edge e+SYNC_STAGES. `wake_pulse` is 1 for the one cycle that follows the edge taking the QUAL_SAMPLES-th consecutive low sample.
- R3: A high sample between low samples restarts the count. A low pulse covering fewer than QUAL_SAMPLES edges, or several such pulses separated by high samples, produces no wake.
- R4: While idle, a sample is counted only on an edge where `sleep_act`, `pin_en` and `level_mode` are all 1 (active-high). On any edge where one of them is 0, the count returns to zero. With any of them held at 0, no wake is issued.
- R5: The start-up length is L = 2^(SU_BASE_LOG2 + SU_STEP_LOG2*`su_sel`) slow cycles. The defaults give `su_sel` 0, 1, 2, 3 → 4, 16, 64, 256. `su_sel` is captured at the wake edge W, and start-up ends at edge W+L.
- R6: At the end edge, `irq_pulse` is driven to 1 for one cycle if and only if that edge's pin sample is low. Otherwise the wake completes with no request.
- R7: `wake_pulse` and `irq_pulse` are each single-cycle pulses and are never 1 in the same cycle.
- R8: During start-up, changes on `pin_in`, `sleep_act` and `su_sel` do not alter the end edge. After the end edge the block is idle with a cleared count. A level still held low therefore needs QUAL_SAMPLES fresh samples, and the next wake follows the edge E+QUAL_SAMPLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Slow oscillator clock, the only clock used |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous interrupt pin, active low |
| sleep_act | input | 1 | High while the system is in deep sleep |
| pin_en | input | 1 | Per-pin enable |
| level_mode | input | 1 | High when the pin is configured for low-level sensing |
| su_sel | input | SEL_W | Start-up length select |
| wake_pulse | output | 1 | One-cycle wake request |
| irq_pulse | output | 1 | One-cycle interrupt request at start-up end |

## Verification
The bench builds the block with SYNC_STAGES=2, QUAL_SAMPLES=2, a 2-bit select, and base and step exponents of 2. With these values every start-up length from 4 to 256 cycles can be swept within the cycle budget. For each length, the bench holds the pin low for one sample, for exactly the qualifying span, for one cycle short of the end edge, and for exactly up to it. Each outcome is predicted from L, QUAL_SAMPLES and SYNC_STAGES, which places the wake-only and wake-plus-request boundaries on exact cycles. The small sample count also makes every combination of the three gating inputs, and a one-cycle gating drop in mid-count, cheap to cover.

// File: rtl/lwq_pkg.sv
package lwq_pkg;

   typedef enum logic [0:0] {
      ST_IDLE    = 1'b0,
      ST_STARTUP = 1'b1
   } lwq_state_e;

   // log2 of the start-up length for a given select value
   function automatic int su_log2(input int base_lg, input int step_lg, input int sel);
      return base_lg + step_lg * sel;
   endfunction

endpackage

// File: rtl/lwq_sync.sv
// Pin sampler: STAGES flops on the slow clock; zero stages passes the pin straight through.
module lwq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic s0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s0 <= RST_VAL;
            else        s0 <= d;
         end
         assign q = s0;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else        sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lwq_qual.sv
// Consecutive-low run counter. hit marks the edge taking the last qualifying sample.
module lwq_qual #(
   parameter int unsigned QUAL_SAMPLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic lo,
   output logic hit
);

   localparam int unsigned RUN_W = (QUAL_SAMPLES > 2) ? $clog2(QUAL_SAMPLES) : 1;
   localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(QUAL_SAMPLES - 1);

   logic [RUN_W-1:0] run;

   assign hit = en && lo && (run == RUN_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run <= '0;
      else if (!en || !lo)      run <= '0;
      else if (run != RUN_TOP)  run <= run + RUN_W'(1);
   end

endmodule

// File: rtl/lwq_startup.sv
// Start-up down-counter. Loaded with L-1 at the wake edge; last is high on the end edge.
module lwq_startup #(
   parameter int unsigned SEL_W        = 2,
   parameter int unsigned SU_BASE_LOG2 = 2,
   parameter int unsigned SU_STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             last
);

   import lwq_pkg::*;

   localparam int MAX_LOG = su_log2(int'(SU_BASE_LOG2), int'(SU_STEP_LOG2), (1 << SEL_W) - 1);
   localparam int CNT_W   = (MAX_LOG < 1) ? 1 : MAX_LOG;

   logic [CNT_W-1:0] cnt;

   // L-1 is a mask of log2(L) ones
   function automatic logic [CNT_W-1:0] load_val(input logic [SEL_W-1:0] s);
      logic [CNT_W-1:0] v;
      v = '0;
      for (int i = 0; i < CNT_W; i++) begin
         if (i < su_log2(int'(SU_BASE_LOG2), int'(SU_STEP_LOG2), int'(s))) v[i] = 1'b1;
      end
      return v;
   endfunction

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (load)             cnt <= load_val(sel);
      else if (run && !last)     cnt <= cnt - CNT_W'(1);
   end

endmodule

// File: rtl/lvl_wake_qual.sv
module lvl_wake_qual #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned QUAL_SAMPLES = 2,
   parameter int unsigned SEL_W        = 2,
   parameter int unsigned SU_BASE_LOG2 = 2,
   parameter int unsigned SU_STEP_LOG2 = 2
) (
   input  logic             clk_osc,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             sleep_act,
   input  logic             pin_en,
   input  logic             level_mode,
   input  logic [SEL_W-1:0] su_sel,
   output logic             wake_pulse,
   output logic             irq_pulse
);

   import lwq_pkg::*;

   localparam int MAX_LOG = su_log2(int'(SU_BASE_LOG2), int'(SU_STEP_LOG2), (1 << SEL_W) - 1);

   // elaboration-time parameter checks
   generate
      if (QUAL_SAMPLES < 2) begin : g_bad_qual
         $error("QUAL_SAMPLES must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("SEL_W must be 1 to 3");
      end
      if (MAX_LOG > 16) begin : g_bad_len
         $error("longest start-up length exceeds 2^16 cycles");
      end
   endgenerate

   lwq_state_e state;
   logic       pin_sync;
   logic       lo_s;
   logic       armed;
   logic       qual_en;
   logic       qual_hit;
   logic       su_last;
   logic       in_startup;
   logic       wake_q;
   logic       irq_q;

   lwq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   assign lo_s       = ~pin_sync;
   assign armed      = sleep_act & pin_en & level_mode;
   assign in_startup = (state == ST_STARTUP);
   assign qual_en    = armed & ~in_startup;

   lwq_qual #(
      .QUAL_SAMPLES (QUAL_SAMPLES)
   ) u_qual (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .en    (qual_en),
      .lo    (lo_s),
      .hit   (qual_hit)
   );

   lwq_startup #(
      .SEL_W        (SEL_W),
      .SU_BASE_LOG2 (SU_BASE_LOG2),
      .SU_STEP_LOG2 (SU_STEP_LOG2)
   ) u_startup (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .load  (qual_hit),
      .run   (in_startup),
      .sel   (su_sel),
      .last  (su_last)
   );

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         wake_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         wake_q <= 1'b0;
         irq_q  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (qual_hit) begin
                  state  <= ST_STARTUP;
                  wake_q <= 1'b1;
               end
            end
            ST_STARTUP: begin
               if (su_last) begin
                  state <= ST_IDLE;
                  irq_q <= lo_s;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wake_pulse = wake_q;
   assign irq_pulse  = irq_q;

endmodule

// File: rtl/lwq_chk.sv
module lwq_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_act,
   input logic pin_en,
   input logic level_mode,
   input logic pin_sync,
   input logic in_startup,
   input logic wake_pulse,
   input logic irq_pulse
);

   a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_pulse && irq_pulse));

   a_r2_wake_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(!pin_sync));

   a_r4_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(sleep_act && pin_en && level_mode));

   a_r6_irq_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ($past(!pin_sync) && $past(in_startup)));

   a_r8_wake_starts: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> in_startup);

   a_r8_irq_idles: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !in_startup);

endmodule

bind lvl_wake_qual lwq_chk u_chk (
   .clk        (clk_osc),
   .rst_n      (rst_n),
   .sleep_act  (sleep_act),
   .pin_en     (pin_en),
   .level_mode (level_mode),
   .pin_sync   (pin_sync),
   .in_startup (in_startup),
   .wake_pulse (wake_pulse),
   .irq_pulse  (irq_pulse)
);

// File: tb/tb_lvl_wake_qual.sv
`timescale 1ns/1ps
module tb_lvl_wake_qual;

   localparam int S    = 2;
   localparam int Q    = 2;
   localparam int SELW = 2;
   localparam int BLG  = 2;
   localparam int SLG  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pin = 1'b1;
   logic            sleep_act = 1'b1;
   logic            pin_en = 1'b1;
   logic            level_mode = 1'b1;
   logic [SELW-1:0] su_sel = '0;
   logic            wake;
   logic            irq;

   int checks = 0;
   int errs   = 0;
   int k_off, fw, fi, nw, ni, both;

   always #2.5 clk = ~clk;

   lvl_wake_qual #(
      .SYNC_STAGES  (S),
      .QUAL_SAMPLES (Q),
      .SEL_W        (SELW),
      .SU_BASE_LOG2 (BLG),
      .SU_STEP_LOG2 (SLG)
   ) dut (
      .clk_osc    (clk),
      .rst_n      (rst_n),
      .pin_in     (pin),
      .sleep_act  (sleep_act),
      .pin_en     (pin_en),
      .level_mode (level_mode),
      .su_sel     (su_sel),
      .wake_pulse (wake),
      .irq_pulse  (irq)
   );

   function automatic int len_of(input int sel);
      return 1 << (BLG + SLG * sel);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic obs_clear();
      k_off = 0; fw = -1; fi = -1; nw = 0; ni = 0; both = 0;
   endtask

   // advance one cycle and sample the outputs away from the active edge
   task automatic step();
      @(negedge clk);
      k_off++;
      if (wake) begin nw++; if (fw < 0) fw = k_off; end
      if (irq)  begin ni++; if (fi < 0) fi = k_off; end
      if (wake && irq) both++;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // hold the pin low for 'hold' edges with start-up select 'sel'
   task automatic run_case(input int sel, input int hold);
      int len, ew, ei, win;
      len = len_of(sel);
      ew  = (hold >= Q) ? S + Q : -1;
      ei  = (hold >= Q + len) ? S + Q + len : -1;
      win = S + Q + len + 6;
      obs_clear();
      su_sel = SELW'(sel);
      pin = 1'b0;
      for (int k = 1; k <= win; k++) begin
         step();
         if (k == hold) pin = 1'b1;
      end
      chk("R2", $sformatf("wake offset sel=%0d hold=%0d", sel, hold), fw, ew);
      chk("R3", $sformatf("wake count sel=%0d hold=%0d", sel, hold), nw, (ew >= 0) ? 1 : 0);
      chk("R5", $sformatf("irq offset sel=%0d hold=%0d", sel, hold), fi, ei);
      chk("R6", $sformatf("irq count sel=%0d hold=%0d", sel, hold), ni, (ei >= 0) ? 1 : 0);
      chk("R7", $sformatf("overlap sel=%0d hold=%0d", sel, hold), both, 0);
      settle(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      // R1: reset with the pin low
      pin = 1'b0;
      obs_clear();
      for (int i = 0; i < 5; i++) step();
      chk("R1", "wake during reset", nw, 0);
      chk("R1", "irq during reset", ni, 0);
      pin = 1'b1;
      rst_n = 1'b1;
      step();
      chk("R1", "wake after reset", int'(wake), 0);
      chk("R1", "irq after reset", int'(irq), 0);
      settle(4);

      // R2 R3 R5 R6 R7: sweep every select value against hold lengths
      for (int sel = 0; sel < (1 << SELW); sel++) begin
         run_case(sel, 1);
         run_case(sel, Q);
         run_case(sel, Q + len_of(sel) - 1);
         run_case(sel, Q + len_of(sel));
      end

      // R3: separated single-edge lows never qualify
      obs_clear();
      su_sel = '0;
      pin = 1'b0;
      for (int k = 1; k <= 14; k++) begin
         step();
         if (k == 1 || k == 3) pin = 1'b1;
         if (k == 2) pin = 1'b0;
      end
      chk("R3", "split lows wake count", nw, 0);
      settle(4);

      // R3: count restarts after a high sample, then qualifies on the second run
      obs_clear();
      pin = 1'b0;
      for (int k = 1; k <= 14; k++) begin
         step();
         if (k == 1) pin = 1'b1;
         if (k == 2) pin = 1'b0;
         if (k == 4) pin = 1'b1;
      end
      chk("R3", "restart wake offset", fw, 2 + S + Q);
      settle(4);

      // R4: every gating combination other than all-ones blocks the wake
      for (int g = 0; g < 7; g++) begin
         obs_clear();
         sleep_act  = g[0];
         pin_en     = g[1];
         level_mode = g[2];
         pin = 1'b0;
         for (int k = 1; k <= 12; k++) step();
         pin = 1'b1;
         for (int k = 1; k <= 4; k++) step();
         chk("R4", $sformatf("gated wake count g=%0d", g), nw, 0);
         sleep_act = 1'b1; pin_en = 1'b1; level_mode = 1'b1;
         settle(4);
      end

      // R4: a one-cycle gating drop mid-count restarts qualification
      obs_clear();
      su_sel = '0;
      pin = 1'b0;
      for (int k = 1; k <= 20; k++) begin
         step();
         if (k == 2) level_mode = 1'b0;
         if (k == 3) level_mode = 1'b1;
         if (k == 5) pin = 1'b1;
      end
      chk("R4", "delayed wake offset", fw, S + Q + 1);
      chk("R4", "delayed wake count", nw, 1);
      chk("R6", "released before end irq count", ni, 0);
      settle(4);

      // R8: disturbances during start-up are ignored; fresh qualification afterwards
      obs_clear();
      su_sel = SELW'(1);
      pin = 1'b0;
      for (int k = 1; k <= S + Q + len_of(1) + Q + 30; k++) begin
         step();
         if (k == 6) begin sleep_act = 1'b0; pin = 1'b1; su_sel = SELW'(3); end
         if (k == 8) pin = 1'b0;
         if (k == 9) begin sleep_act = 1'b1; su_sel = SELW'(1); end
         if (k == S + Q + len_of(1) + Q) pin = 1'b1;
      end
      chk("R8", "first wake offset", fw, S + Q);
      chk("R8", "irq offset after disturbed start-up", fi, S + Q + len_of(1));
      chk("R8", "wake count incl. rewake", nw, 2);
      chk("R8", "irq count", ni, 1);
      chk("R7", "overlap in rewake run", both, 0);
      settle(4);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule